// File: doc/BRIEF.md
# Two-Port Memory Arbiter with Hold-Off

This block decides which of two requesters may drive a single shared memory. Each requester raises its own request line to ask for the memory and holds it high until its transfer is finished. Dropping the line releases the memory. Port 1 owns the memory whenever nobody else has claimed it. Port 2 takes over in two cases: when it asks while port 1 is idle, or when both ports start asking in the same clock cycle. A port that has been granted keeps the memory until it drops its own line. A transfer already running on port 1 is never interrupted.

A new request from port 1 is recognised by comparing its request line with a registered copy of that line from the previous cycle. The request line is never used as a clock. The arbiter drives a one-bit select for the memory-side multiplexer and one grant flag per port. All outputs come straight from flops, so they can feed wide multiplexers without adding logic depth. Reset is synchronous and active high.

Top module: `arb2_mem_arbiter`

## Requirements
- R1: While reset is high at a clock edge, the following cycle shows `sel`=0, `gnt_p1`=1 and `gnt_p2`=0. In this encoding, `sel`=0 means port 1 owns the memory and `sel`=1 means port 2 owns it.
- R2: Exactly one grant flag is high in every cycle after reset, and `gnt_p2` always equals `sel`.
- R3: If port 1 owns the memory, port 2 requests, and port 1's request is low, then port 2 owns the memory after the next edge.
- R4: If port 1 owns the memory and both requests go from low to high together, port 2 owns the memory after the next edge.
- R5: If port 1's request was high in the previous cycle and is still high, port 1 keeps the memory even when port 2 requests.
- R6: A port 2 request held back by R5 is granted at the first edge at which port 1's request is low.
- R7: While port 2 owns the memory and keeps its request high, it keeps the memory whatever port 1 does.
- R8: When port 2 owns the memory and its request is low at an edge, ownership returns to port 1 after that edge.
- R9: Reset clears the stored previous value of port 1's request. A port 1 request held high through reset therefore counts as new at the first edge after reset, so if port 2 is also requesting, port 2 is granted (R4).
- R10: While port 2's request is low, port 1 keeps the memory whatever its own request does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_p1 | input | 1 | Port 1 request; held high while port 1 is being served |
| req_p2 | input | 1 | Port 2 request; held high while port 2 is being served |
| sel | output | 1 | Memory owner, registered: 0 means port 1, 1 means port 2 |
| gnt_p1 | output | 1 | Port 1 grant flag, registered |
| gnt_p2 | output | 1 | Port 2 grant flag, registered |

## Verification
The block has no parameters, so the bench builds its only configuration. In that configuration the bench can reach every transition of the two-state controller. The cases that matter most are where port 1's request was already high in the previous cycle and where it rises in the same cycle as port 2's. The bench also holds both requests high through reset, which shows whether reset clears the stored copy of port 1's request.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  typedef enum logic {
    OWNER_P1 = 1'b0,
    OWNER_P2 = 1'b1
  } owner_t;
endpackage

// File: rtl/arb2_rise_detect.sv
module arb2_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rising
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rising = level & ~level_q;
endmodule

// File: rtl/arb2_owner_fsm.sv
module arb2_owner_fsm
  import arb2_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_p1,
  input  logic   req_p2,
  input  logic   p1_new,
  output owner_t owner,
  output owner_t owner_nxt
);
  always_comb begin
    owner_nxt = owner;
    unique case (owner)
      OWNER_P1: if (req_p2 && (!req_p1 || p1_new)) owner_nxt = OWNER_P2;
      OWNER_P2: if (!req_p2)                       owner_nxt = OWNER_P1;
      default:                                     owner_nxt = OWNER_P1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) owner <= OWNER_P1;
    else     owner <= owner_nxt;
  end
endmodule

// File: rtl/arb2_grant_reg.sv
module arb2_grant_reg
  import arb2_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  owner_t owner_nxt,
  output logic   gnt_p1,
  output logic   gnt_p2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_p1 <= 1'b1;
      gnt_p2 <= 1'b0;
    end else begin
      gnt_p1 <= (owner_nxt == OWNER_P1);
      gnt_p2 <= (owner_nxt == OWNER_P2);
    end
  end
endmodule

// File: rtl/arb2_mem_arbiter.sv
module arb2_mem_arbiter
  import arb2_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_p1,
  input  logic req_p2,
  output logic sel,
  output logic gnt_p1,
  output logic gnt_p2
);
  logic   p1_new;
  owner_t owner;
  owner_t owner_nxt;

  arb2_rise_detect u_rise (
    .clk    (clk),
    .rst    (rst),
    .level  (req_p1),
    .rising (p1_new)
  );

  arb2_owner_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_p1    (req_p1),
    .req_p2    (req_p2),
    .p1_new    (p1_new),
    .owner     (owner),
    .owner_nxt (owner_nxt)
  );

  arb2_grant_reg u_gnt (
    .clk       (clk),
    .rst       (rst),
    .owner_nxt (owner_nxt),
    .gnt_p1    (gnt_p1),
    .gnt_p2    (gnt_p2)
  );

  assign sel = (owner == OWNER_P2);
endmodule

// File: rtl/arb2_mem_arbiter_chk.sv
module arb2_mem_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic req_p1,
  input logic req_p2,
  input logic sel,
  input logic gnt_p1,
  input logic gnt_p2
);
  logic p1_prev;

  always_ff @(posedge clk) begin
    if (rst) p1_prev <= 1'b0;
    else     p1_prev <= req_p1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sel && gnt_p1 && !gnt_p2));

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones({gnt_p1, gnt_p2}) == 1) && (gnt_p2 == sel));

  // R3 R4 R6 R9
  take_p2_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel && req_p2 && (!req_p1 || !p1_prev)) |=> sel);

  // R5
  hold_p1_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel && req_p1 && p1_prev) |=> !sel);

  // R7
  keep_p2_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && req_p2) |=> sel);

  // R8
  release_p2_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !req_p2) |=> !sel);

  // R10
  idle_p1_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel && !req_p2) |=> !sel);
endmodule

bind arb2_mem_arbiter arb2_mem_arbiter_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .req_p1 (req_p1),
  .req_p2 (req_p2),
  .sel    (sel),
  .gnt_p1 (gnt_p1),
  .gnt_p2 (gnt_p2)
);

// File: tb/arb2_mem_arbiter_test.sv
module arb2_mem_arbiter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_p1 = 1'b0;
  logic req_p2 = 1'b0;
  logic sel, gnt_p1, gnt_p2;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  arb2_mem_arbiter uut (
    .clk    (clk),
    .rst    (rst),
    .req_p1 (req_p1),
    .req_p2 (req_p2),
    .sel    (sel),
    .gnt_p1 (gnt_p1),
    .gnt_p2 (gnt_p2)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic expect_owner(input string tag, input logic exp_sel);
    checks++;
    if (sel !== exp_sel || gnt_p1 !== ~exp_sel || gnt_p2 !== exp_sel) begin
      errors++;
      $display("FAIL %s: sel/gnt_p1/gnt_p2 = %b%b%b expected %b%b%b",
               tag, sel, gnt_p1, gnt_p2, exp_sel, ~exp_sel, exp_sel);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; req_p1 = 1'b0; req_p2 = 1'b0;
    cyc(); cyc();
    expect_owner("R1 reset state", 1'b0);
    rst = 1'b0;
    cyc();
    expect_owner("R2 idle after reset", 1'b0);
  endtask

  task automatic t_p1_only();
    req_p2 = 1'b0;
    req_p1 = 1'b1; cyc(); expect_owner("R10 p1 rises, p2 idle", 1'b0);
    cyc();              expect_owner("R10 p1 held, p2 idle", 1'b0);
    req_p1 = 1'b0; cyc(); expect_owner("R10 p1 drops, p2 idle", 1'b0);
  endtask

  task automatic t_p2_when_idle();
    req_p1 = 1'b0; req_p2 = 1'b1;
    cyc(); expect_owner("R3 p2 granted while p1 idle", 1'b1);
    req_p1 = 1'b1;
    cyc(); expect_owner("R7 p2 kept while p1 rises", 1'b1);
    cyc(); expect_owner("R7 p2 kept while p1 held", 1'b1);
    req_p2 = 1'b0;
    cyc(); expect_owner("R8 return to p1 on p2 drop", 1'b0);
    req_p1 = 1'b0;
    cyc(); expect_owner("R10 idle after return", 1'b0);
  endtask

  task automatic t_simultaneous();
    req_p1 = 1'b0; req_p2 = 1'b0; cyc();
    req_p1 = 1'b1; req_p2 = 1'b1;
    cyc(); expect_owner("R4 simultaneous new requests go to p2", 1'b1);
    req_p2 = 1'b0;
    cyc(); expect_owner("R8 p2 releases", 1'b0);
    cyc(); expect_owner("R10 p1 keeps with p2 idle", 1'b0);
    req_p1 = 1'b0; cyc();
  endtask

  task automatic t_hold_off();
    req_p1 = 1'b1; req_p2 = 1'b0;
    cyc(); expect_owner("R10 p1 transfer starts", 1'b0);
    req_p2 = 1'b1;
    cyc(); expect_owner("R5 p2 waits on busy p1", 1'b0);
    cyc(); expect_owner("R5 p2 still waits", 1'b0);
    req_p1 = 1'b0;
    cyc(); expect_owner("R6 p2 granted after p1 drops", 1'b1);
    req_p2 = 1'b0;
    cyc(); expect_owner("R8 p2 done", 1'b0);
  endtask

  task automatic t_reset_clears_copy();
    rst = 1'b1; req_p1 = 1'b1; req_p2 = 1'b1;
    cyc(); cyc();
    expect_owner("R1 reset wins over requests", 1'b0);
    rst = 1'b0;
    cyc(); expect_owner("R9 p1 held through reset counts as new", 1'b1);
    req_p1 = 1'b0; req_p2 = 1'b0;
    cyc(); expect_owner("R8 release after reset case", 1'b0);
  endtask

  initial begin
    cyc();
    t_reset();
    t_p1_only();
    t_p2_when_idle();
    t_simultaneous();
    t_hold_off();
    t_reset_clears_copy();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule